// File: doc/BRIEF.md
# Iterative Modular Inverse Unit

This block finds the multiplicative inverse of a 17-bit unsigned operand with respect to the prime modulus 65537. It uses the extended Euclidean method. A pair of dividend/divisor registers is reduced by repeated integer division. Alongside it, a pair of signed Bezout coefficients is updated from each quotient. The loop ends when a division leaves no remainder, so the number of iterations depends on the operand.

The client raises `start` for one cycle with the operand on `uIn`. The unit then asserts `busy`. When the answer is ready it pulses `outValid` for one cycle. `result` and `noInverse` keep their values until the next answer is produced. The block contains its own divider, which produces one quotient bit per clock, and its own signed multiplier. The caller needs nothing else.

Top module: `modinv_unit`

## Requirements
- R1: An operand of 0 yields result 0 with `noInverse` low. No division is run, and `outValid` rises two cycles after the accepting clock edge.
- R2: A `start` sampled while `busy` is low is accepted. `busy` is high from the next cycle until the cycle in which `outValid` pulses.
- R3: For any operand not divisible by 65537, `result` lies in 0..65536 and `uIn * result mod 65537 = 1`.
- R4: Operands from 65537 up to 131071 are reduced implicitly. The answer equals the inverse of `uIn mod 65537`.
- R5: The operand 65537 has no inverse. `noInverse` goes high and `result` is 0.
- R6: `outValid` is a single-cycle pulse and `busy` is low during it. `result` and `noInverse` stay unchanged until the next pulse.
- R7: A `start` raised while `busy` is high is ignored. The running computation finishes with its own answer, and no extra `outValid` follows.
- R8: A `start` raised in the same cycle as `outValid` is accepted. Every computation begins from freshly loaded registers (dividend 65537, divisor `uIn`, coefficients 0 and 1), so nothing carries over from the previous operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; takes `uIn` when idle |
| uIn | input | 17 | Operand to invert |
| result | output | 17 | Inverse modulo 65537, held between answers |
| outValid | output | 1 | One-cycle strobe marking a new answer |
| busy | output | 1 | A computation is in progress |
| noInverse | output | 1 | The last operand had no inverse |

## Verification
The delivery of one answer and the acceptance of the next request can fall in the same cycle: `outValid` pulses exactly when the controller returns to idle. The bench provokes this on every operand after the first. Each new `start` is driven in the very cycle where `outValid` is seen, so answers follow one another with no gap. Each answer is judged against an inverse that the bench computes by modular exponentiation. The bench also confirms that the product with the operand reduces to 1, which would expose stale coefficients left over from the previous run.

// File: rtl/modinv_pkg.sv
package modinv_pkg;
  // strobes issued by the controller to the datapath
  typedef struct packed {
    logic load;   // capture operand and initial values
    logic divGo;  // launch one division
    logic macEn;  // advance both loops by one step
    logic finish; // form the answer
  } ctrl_t;
endpackage

// File: rtl/modinv_divider.sv
module modinv_divider #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  localparam int CNTW = $clog2(W) + 1;

  logic [W-1:0]    quo;
  logic [W-1:0]    rem;
  logic [W-1:0]    dsr;
  logic [CNTW-1:0] cnt;
  logic            running;
  logic [W:0]      trial;

  assign trial = {rem, quo[W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo     <= '0;
      rem     <= '0;
      dsr     <= '0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo     <= dividend;
        rem     <= '0;
        dsr     <= divisor;
        cnt     <= '0;
        running <= 1'b1;
      end else if (running) begin
        // restoring step: keep the difference only when it is non-negative
        if (trial >= {1'b0, dsr}) begin
          rem <= W'(trial - {1'b0, dsr});
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CNTW'(W - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo;
  assign remainder = rem;
endmodule

// File: rtl/modinv_ctrl.sv
module modinv_ctrl
  import modinv_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  uZero,
  input  logic  divDone,
  input  logic  remZero,
  output ctrl_t strb,
  output logic  busy
);
  typedef enum logic [2:0] {S_IDLE, S_DGO, S_DWAIT, S_MAC, S_FIN} state_t;

  state_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.load = 1'b1;
        nextState = uZero ? S_FIN : S_DGO;
      end
      S_DGO: begin
        strb.divGo = 1'b1;
        nextState  = S_DWAIT;
      end
      S_DWAIT: if (divDone) nextState = remZero ? S_FIN : S_MAC;
      S_MAC: begin
        strb.macEn = 1'b1;
        nextState  = S_DGO;
      end
      S_FIN: begin
        strb.finish = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/modinv_datapath.sv
module modinv_datapath
  import modinv_pkg::*;
#(
  parameter int W   = 17,
  parameter int CW  = W + 2,
  parameter int MOD = 65537
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        strb,
  input  logic [W-1:0] uIn,
  output logic         uZero,
  output logic         divDone,
  output logic         remZero,
  output logic [W-1:0] result,
  output logic         noInverse,
  output logic         outValid
);
  localparam logic [W-1:0]         MODW = W'(MOD);
  localparam logic signed [CW-1:0] MODC = CW'(MOD);

  logic [W-1:0]         n1, n2, q, r;
  logic signed [CW-1:0] b1, b2, qExt, prod, nextB2, fixB;
  logic                 zeroCase;

  modinv_divider #(.W(W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (n1),
    .divisor  (n2),
    .quotient (q),
    .remainder(r),
    .done     (divDone)
  );

  assign uZero   = (uIn == '0);
  assign remZero = (r == '0);

  // signed multiply-accumulate; true values stay well inside CW bits
  assign qExt   = $signed({{(CW - W){1'b0}}, q});
  assign prod   = qExt * b2;
  assign nextB2 = b1 - prod;
  assign fixB   = b2[CW-1] ? (b2 + MODC) : b2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      n1        <= '0;
      n2        <= '0;
      b1        <= '0;
      b2        <= '0;
      zeroCase  <= 1'b0;
      result    <= '0;
      noInverse <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strb.finish;
      if (strb.load) begin
        n1       <= MODW;
        n2       <= uIn;
        b1       <= '0;
        b2       <= CW'(1);
        zeroCase <= uZero;
      end else if (strb.macEn) begin
        n1 <= n2;
        n2 <= r;
        b1 <= b2;
        b2 <= nextB2;
      end
      if (strb.finish) begin
        if (zeroCase) begin
          result    <= '0;
          noInverse <= 1'b0;
        end else if (n2 != W'(1)) begin
          result    <= '0;
          noInverse <= 1'b1;
        end else begin
          result    <= fixB[W-1:0];
          noInverse <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/modinv_unit.sv
module modinv_unit
  import modinv_pkg::*;
#(
  parameter int W   = 17,
  parameter int CW  = W + 2,
  parameter int MOD = 65537
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] uIn,
  output logic [W-1:0] result,
  output logic         outValid,
  output logic         busy,
  output logic         noInverse
);
  ctrl_t strb;
  logic  uZero, divDone, remZero;

  modinv_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .uZero  (uZero),
    .divDone(divDone),
    .remZero(remZero),
    .strb   (strb),
    .busy   (busy)
  );

  modinv_datapath #(.W(W), .CW(CW), .MOD(MOD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .uIn      (uIn),
    .uZero    (uZero),
    .divDone  (divDone),
    .remZero  (remZero),
    .result   (result),
    .noInverse(noInverse),
    .outValid (outValid)
  );
endmodule

// File: rtl/modinv_chk.sv
module modinv_chk
  import modinv_pkg::*;
#(
  parameter int W   = 17,
  parameter int MOD = 65537
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [W-1:0] uIn,
  input logic [W-1:0] result,
  input logic         outValid,
  input logic         busy,
  input logic         noInverse,
  input ctrl_t        strb,
  input logic         divDone
);
  a_r1_zero_quick: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (uIn == '0) |=> ##1 (outValid && result == '0 && !noInverse));

  a_r1_zero_nodiv: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (uIn == '0) |=> !strb.divGo);

  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  a_r2_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> busy);

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.divGo, strb.macEn, strb.finish}));

  a_r3_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result < W'(MOD)));

  a_r5_noinv_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid && noInverse |-> (result == '0));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r6_idle: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(result) && $stable(noInverse)));
endmodule

bind modinv_unit modinv_chk #(.W(W), .MOD(MOD)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .uIn      (uIn),
  .result   (result),
  .outValid (outValid),
  .busy     (busy),
  .noInverse(noInverse),
  .strb     (strb),
  .divDone  (divDone)
);

// File: tb/sim_modinv_unit.sv
module sim_modinv_unit;
  localparam longint M = 65537;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [16:0] uIn = '0;
  logic [16:0] result;
  logic        outValid, busy, noInverse;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  modinv_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .uIn(uIn),
    .result(result), .outValid(outValid), .busy(busy), .noInverse(noInverse)
  );

  function automatic longint refInv(longint u);
    longint x = u % M;
    longint acc = 1;
    longint e = M - 2;
    if (x == 0) return 0;
    while (e > 0) begin
      if (e[0]) acc = (acc * x) % M;
      x = (x * x) % M;
      e = e >> 1;
    end
    return acc;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where outValid is seen
  task automatic runOp(input logic [16:0] u, output int lat);
    int guard = 0;
    while (busy) @(negedge clk);
    uIn = u;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!outValid && guard < 2000) begin
      @(negedge clk);
      lat++;
      guard++;
    end
  endtask

  task automatic judge(input logic [16:0] u, input string req);
    longint uu = longint'(u);
    chk({req, " valid"}, outValid, 1);
    chk({req, " busy low R6"}, busy, 0);
    if (uu % M == 0 && uu != 0) begin
      chk({req, " noInverse R5"}, noInverse, 1);
      chk({req, " result R5"}, result, 0);
    end else begin
      chk({req, " value R3"}, result, refInv(uu));
      chk({req, " noInverse"}, noInverse, 0);
      if (uu != 0) chk({req, " product R3"}, (uu * result) % M, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int extra;
    logic [16:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R6 reset result", result, 0);
    chk("R2 reset busy", busy, 0);
    chk("R6 reset outValid", outValid, 0);
    chk("R5 reset noInverse", noInverse, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero operand
    runOp(17'd0, lat);
    chk("R1 zero latency", lat, 2);
    chk("R1 zero result", result, 0);
    chk("R1 zero noInverse", noInverse, 0);

    // directed corners, back to back (R8)
    runOp(17'd1, lat);      judge(17'd1, "R3 u=1");
    runOp(17'd65536, lat);  judge(17'd65536, "R3 u=65536");
    runOp(17'd65537, lat);  judge(17'd65537, "R5 u=65537");
    runOp(17'd65538, lat);  judge(17'd65538, "R4 u=65538");
    runOp(17'd131071, lat); judge(17'd131071, "R4 u=131071");
    runOp(17'd2, lat);      judge(17'd2, "R8 after max");
    runOp(17'd0, lat);      chk("R8 zero after op", result, 0);
    runOp(17'd12345, lat);  judge(17'd12345, "R8 after zero");

    // R6: hold after the pulse
    held = result;
    repeat (3) @(negedge clk);
    chk("R6 held result", result, held);
    chk("R6 pulse ended", outValid, 0);

    // R7: start while busy ignored
    uIn = 17'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 busy during op", busy, 1);
    uIn = 17'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    uIn = 17'd9;
    while (!outValid) @(negedge clk);
    chk("R7 answer of first op", result, refInv(3));
    extra = 0;
    repeat (80) begin
      @(negedge clk);
      if (outValid) extra++;
    end
    chk("R7 no extra pulse", extra, 0);

    // random operands over the full 17-bit range, back to back
    for (int i = 0; i < 200; i++) begin
      logic [16:0] u;
      u = 17'($urandom % 131072);
      runOp(u, lat);
      judge(u, (u >= 17'd65537) ? "R4 random" : "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule